// File: doc/BRIEF.md
# Chained Radix-2 Montgomery Multiplier Array

This block computes a radix-2 Montgomery product of a pre-scaled multiplier `X` (NBITS+1 bits), a multiplicand `Y` and the halved modulus `M^ = (M+1)/2` of an odd modulus `M`. The operands are cut into E = NBITS/WORD_W + 1 words of WORD_W bits. A chain of NPE processing elements works on the sum: each element takes one bit of `X` and sweeps every word of the running sum `Z`, `Y` and `M^`, least significant word first. A pass through the chain therefore retires NPE bits of `X`. Each element starts one cycle after the element before it. To do this, it computes every output word for both values of the bit it does not yet know, which is bit 0 of the next incoming word. It picks the right result when that bit arrives.

The words leaving the last element go into a FIFO of E entries and are fed back to the first element on the next pass. The first pass starts from a sum of zero. If the chain is longer than the word sweep allows (NPE+2 > E), the first element waits on an empty FIFO. Otherwise the recirculated words are already waiting when it needs them. Bit slots beyond bit NBITS in the last pass pass the sum through unchanged. The result is left in partly reduced form: final subtraction and domain conversion belong to the caller.

Top module: `montRadix2Array`

## Requirements
- R1: After done, zOut multiplied by 2^NBITS is congruent to xIn·Y modulo M. All NBITS+1 bits of xIn are processed, bit 0 first.
- R2: The result satisfies 0 <= zOut < 3·M, given Y < M and M odd with M < 2^NBITS.
- R3: If xIn is zero or yIn is zero, zOut is exactly zero.
- R4: done is high for exactly one cycle per operation. Count the start edge as cycle 0. With K = ceil((NBITS+1)/NPE), done is high in cycle D = (K-1)·max(E, NPE+2) + E + NPE + 2. zOut holds its value from cycle D until the next operation's final pass.
- R5: After reset, busy, done and zOut are zero. busy is high from cycle 1 to cycle D-1 and low in cycle D.
- R6: While busy, start and any change to xIn, yIn or mHatIn are ignored. The running operation keeps its result, its done cycle and its single done pulse.
- R7: When NPE+2 > E, each pass after the first begins NPE+2 cycles after the previous pass began, because the first element waits for recirculated words. The result still follows R1.
- R8: A bit slot whose index exceeds NBITS leaves the sum unchanged, so R1 also holds when K·NPE > NBITS+1.
- R9: The recirculation FIFO holds at most E words and is never read while empty. The words of one pass enter the first element on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| xIn | input | NBITS+1 | Pre-scaled multiplier X |
| yIn | input | E·WORD_W | Multiplicand Y, less than M |
| mHatIn | input | E·WORD_W | Halved modulus (M+1)/2 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| zOut | output | E·WORD_W | Montgomery product, partly reduced |

## Verification
The hardest case is a chain long enough that the first element stalls on an empty FIFO between passes. This must combine with trailing bit slots that have to pass the sum through. Neither case shows at the ports except through the result and the done cycle. The bench therefore runs two instances side by side on the same operands. One has a short chain whose recirculated words arrive early. The other has NPE=10, so it stalls on every pass and has three surplus slots. The bench checks the result and the exact done cycle of each against the formula. A start pulse with changed operands is injected mid-run to show that a busy operation ignores it.

// File: rtl/mmPkg.sv
package mmPkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;        // capture operands
    logic issue;       // send one word into the chain
    logic pop;         // take that word from the recirculation FIFO
    logic firstKernel; // word belongs to the first pass (sum is zero)
    logic wordFirst;   // lowest word of a sweep
    logic wordLast;    // highest word of a sweep
    logic finKernel;   // word belongs to the final pass
  } mmCtrlT;
endpackage

// File: rtl/mmPe.sv
module mmPe #(
  parameter int W   = 4,
  parameter int P   = 2,
  parameter int IDX = 0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         iValid,
  input  logic         iFirst,
  input  logic         iLast,
  input  logic         iFin,
  input  logic [W-1:0] iZ,
  input  logic [W-1:0] iY,
  input  logic [W-1:0] iM,
  input  logic [P-1:0] iXv,
  input  logic [P-1:0] iEnv,
  output logic         oValid,
  output logic         oFirst,
  output logic         oLast,
  output logic         oFin,
  output logic [W-1:0] oZ,
  output logic [W-1:0] oY,
  output logic [W-1:0] oM,
  output logic [P-1:0] oXv,
  output logic [P-1:0] oEnv
);
  localparam int SW = W + 2;

  logic         qReg, xReg, enReg;
  logic [W-2:0] lowReg;
  logic         top0, top1;
  logic [1:0]   cy0, cy1;

  logic         curX, curQ, curEn, selHi;
  logic [1:0]   cin;
  logic [SW-1:0] base, addend, sum0, sum1;

  // the bit shifted into the top of the pending word is bit 0 of the word
  // arriving now; past the top word it is zero
  assign selHi = oLast ? 1'b0 : iZ[0];
  assign oZ    = {(selHi ? top1 : top0), lowReg};

  always_comb begin
    curEn  = iFirst ? iEnv[IDX] : enReg;
    curX   = iFirst ? iXv[IDX]  : xReg;
    curQ   = iFirst ? iZ[0]     : qReg;
    cin    = iFirst ? 2'b00 : (selHi ? cy1 : cy0);
    base   = {3'b000, iZ[W-1:1]};
    addend = (curQ ? {2'b00, iM} : '0) + (curX ? {2'b00, iY} : '0) + {{(SW-2){1'b0}}, cin};
    sum0   = base + addend;
    sum1   = sum0 + (SW'(1) << (W - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oValid <= 1'b0; oFirst <= 1'b0; oLast <= 1'b0; oFin <= 1'b0;
      oY <= '0; oM <= '0; oXv <= '0; oEnv <= '0;
      qReg <= 1'b0; xReg <= 1'b0; enReg <= 1'b0;
      lowReg <= '0; top0 <= 1'b0; top1 <= 1'b0; cy0 <= '0; cy1 <= '0;
    end else begin
      oValid <= iValid;
      oFirst <= iFirst;
      oLast  <= iLast;
      oFin   <= iFin;
      oY     <= iY;
      oM     <= iM;
      oXv    <= iXv;
      oEnv   <= iEnv;
      if (iValid) begin
        if (iFirst) begin
          qReg  <= iZ[0];
          xReg  <= iXv[IDX];
          enReg <= iEnv[IDX];
        end
        if (curEn) begin
          lowReg <= sum0[W-2:0];
          top0   <= sum0[W-1];
          top1   <= sum1[W-1];
          cy0    <= sum0[SW-1:W];
          cy1    <= sum1[SW-1:W];
        end else begin
          lowReg <= iZ[W-2:0];
          top0   <= iZ[W-1];
          top1   <= iZ[W-1];
          cy0    <= '0;
          cy1    <= '0;
        end
      end
    end
  end

  // R9: a pending inner word is always followed at once by the next word of the same sweep
  a_r9_sweep_contiguous: assert property (@(posedge clk) disable iff (!rstN)
    (oValid && !oLast) |-> (iValid && !iFirst));

  // R8: a disabled slot gives both candidates the same top bit
  a_r8_bypass_no_guess: assert property (@(posedge clk) disable iff (!rstN)
    (iValid && !curEn) |=> (top0 == top1));
endmodule

// File: rtl/mmFifo.sv
module mmFifo #(
  parameter int W     = 4,
  parameter int DEPTH = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count;

  assign head  = mem[rdPtr];
  assign empty = (count == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wrPtr] <= pushData;
        wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (pop) rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop) |-> (count < CW'(DEPTH)));
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);
endmodule

// File: rtl/mmCtrl.sv
module mmCtrl
  import mmPkg::*;
#(
  parameter int NBITS  = 16,
  parameter int WORD_W = 4,
  parameter int NPE    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic fifoEmpty,
  input  logic finalCap,
  output mmCtrlT ctrl,
  output logic [((NBITS+NPE)/NPE > 1 ? $clog2((NBITS+NPE)/NPE) : 1)-1:0] kIdx,
  output logic [((NBITS/WORD_W+1) > 1 ? $clog2(NBITS/WORD_W+1) : 1)-1:0] wIdx,
  output logic busy,
  output logic done
);
  localparam int E  = NBITS / WORD_W + 1;
  localparam int K  = (NBITS + NPE) / NPE;   // ceil((NBITS+1)/NPE)
  localparam int KW = (K > 1) ? $clog2(K) : 1;
  localparam int EW = (E > 1) ? $clog2(E) : 1;

  typedef enum logic [1:0] {sIdle, sIssue, sDrain} stateT;
  stateT state;
  logic  issueOk;

  assign issueOk = (state == sIssue) && ((kIdx == '0) || !fifoEmpty);
  assign busy    = (state != sIdle);

  always_comb begin
    ctrl.load        = (state == sIdle) && start;
    ctrl.issue       = issueOk;
    ctrl.pop         = issueOk && (kIdx != '0);
    ctrl.firstKernel = (kIdx == '0);
    ctrl.wordFirst   = (wIdx == '0);
    ctrl.wordLast    = (wIdx == EW'(E - 1));
    ctrl.finKernel   = (kIdx == KW'(K - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= sIdle;
      kIdx  <= '0;
      wIdx  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        sIdle: if (start) begin
          state <= sIssue;
          kIdx  <= '0;
          wIdx  <= '0;
        end
        sIssue: if (issueOk) begin
          if (ctrl.wordLast) begin
            wIdx <= '0;
            if (ctrl.finKernel) state <= sDrain;
            else                kIdx  <= kIdx + 1'b1;
          end else begin
            wIdx <= wIdx + 1'b1;
          end
        end
        sDrain: if (finalCap) begin
          state <= sIdle;
          done  <= 1'b1;
        end
        default: state <= sIdle;
      endcase
    end
  end

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r5_idle_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r6_start_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !finalCap) |=> busy);
  a_r9_issue_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    (issueOk && !ctrl.wordLast) |=> issueOk);
endmodule

// File: rtl/mmDatapath.sv
module mmDatapath
  import mmPkg::*;
#(
  parameter int NBITS  = 16,
  parameter int WORD_W = 4,
  parameter int NPE    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  mmCtrlT ctrl,
  input  logic [((NBITS+NPE)/NPE > 1 ? $clog2((NBITS+NPE)/NPE) : 1)-1:0] kIdx,
  input  logic [((NBITS/WORD_W+1) > 1 ? $clog2(NBITS/WORD_W+1) : 1)-1:0] wIdx,
  input  logic [NBITS:0] xIn,
  input  logic [(NBITS/WORD_W+1)*WORD_W-1:0] yIn,
  input  logic [(NBITS/WORD_W+1)*WORD_W-1:0] mHatIn,
  output logic fifoEmpty,
  output logic finalCap,
  output logic [(NBITS/WORD_W+1)*WORD_W-1:0] zOut
);
  localparam int W  = WORD_W;
  localparam int E  = NBITS / WORD_W + 1;
  localparam int ZW = E * W;
  localparam int EW = (E > 1) ? $clog2(E) : 1;

  logic [NBITS:0]  opX;
  logic [ZW-1:0]   opY, opM;
  logic [W-1:0]    fifoHead;
  logic            push;
  logic [EW-1:0]   capIdx;
  logic [NPE-1:0]  xvNext, envNext;

  // stream stage k feeds element k; stage NPE is the chain output
  logic         sV [NPE+1];
  logic         sF [NPE+1];
  logic         sL [NPE+1];
  logic         sN [NPE+1];
  logic [W-1:0] sZ [NPE+1];
  logic [W-1:0] sY [NPE+1];
  logic [W-1:0] sM [NPE+1];
  logic [NPE-1:0] sX [NPE+1];
  logic [NPE-1:0] sE [NPE+1];

  // bit slot k of the current pass handles X bit kIdx*NPE+k
  always_comb begin
    for (int k = 0; k < NPE; k++) begin
      int b;
      logic [NBITS:0] shifted;
      b          = int'(kIdx) * NPE + k;
      shifted    = opX >> b;
      envNext[k] = (b <= NBITS);
      xvNext[k]  = envNext[k] & shifted[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opX <= '0; opY <= '0; opM <= '0;
      sV[0] <= 1'b0; sF[0] <= 1'b0; sL[0] <= 1'b0; sN[0] <= 1'b0;
      sZ[0] <= '0; sY[0] <= '0; sM[0] <= '0; sX[0] <= '0; sE[0] <= '0;
    end else begin
      if (ctrl.load) begin
        opX <= xIn;
        opY <= yIn;
        opM <= mHatIn;
      end
      sV[0] <= ctrl.issue;
      sF[0] <= ctrl.wordFirst;
      sL[0] <= ctrl.wordLast;
      sN[0] <= ctrl.finKernel;
      sZ[0] <= ctrl.firstKernel ? '0 : fifoHead;
      sY[0] <= opY[int'(wIdx)*W +: W];
      sM[0] <= opM[int'(wIdx)*W +: W];
      sX[0] <= xvNext;
      sE[0] <= envNext;
    end
  end

  for (genvar k = 0; k < NPE; k++) begin : gPe
    mmPe #(.W(W), .P(NPE), .IDX(k)) pe_i (
      .clk(clk), .rstN(rstN),
      .iValid(sV[k]), .iFirst(sF[k]), .iLast(sL[k]), .iFin(sN[k]),
      .iZ(sZ[k]), .iY(sY[k]), .iM(sM[k]), .iXv(sX[k]), .iEnv(sE[k]),
      .oValid(sV[k+1]), .oFirst(sF[k+1]), .oLast(sL[k+1]), .oFin(sN[k+1]),
      .oZ(sZ[k+1]), .oY(sY[k+1]), .oM(sM[k+1]), .oXv(sX[k+1]), .oEnv(sE[k+1])
    );
  end

  assign push     = sV[NPE] && !sN[NPE];
  assign finalCap = sV[NPE] && sN[NPE] && sL[NPE];

  mmFifo #(.W(W), .DEPTH(E)) fifo_i (
    .clk(clk), .rstN(rstN),
    .push(push), .pushData(sZ[NPE]),
    .pop(ctrl.pop), .head(fifoHead), .empty(fifoEmpty)
  );

  // final-pass words land in the result register, lowest word first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zOut   <= '0;
      capIdx <= '0;
    end else if (sV[NPE] && sN[NPE]) begin
      zOut[int'(sF[NPE] ? '0 : capIdx)*W +: W] <= sZ[NPE];
      capIdx <= sL[NPE] ? '0 : ((sF[NPE] ? '0 : capIdx) + 1'b1);
    end
  end

  // R9: the chain output never carries a pass's words with a gap
  a_r9_output_contiguous: assert property (@(posedge clk) disable iff (!rstN)
    (sV[NPE] && !sL[NPE]) |=> (sV[NPE] && !sF[NPE]));
  // R6: operands stay fixed while a word of the current operation is in flight
  a_r6_operands_held: assert property (@(posedge clk) disable iff (!rstN)
    (sV[0] && !ctrl.load) |=> $stable(opX));
endmodule

// File: rtl/montRadix2Array.sv
module montRadix2Array
  import mmPkg::*;
#(
  parameter int NBITS  = 16,
  parameter int WORD_W = 4,
  parameter int NPE    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic [NBITS:0] xIn,
  input  logic [(NBITS/WORD_W+1)*WORD_W-1:0] yIn,
  input  logic [(NBITS/WORD_W+1)*WORD_W-1:0] mHatIn,
  output logic busy,
  output logic done,
  output logic [(NBITS/WORD_W+1)*WORD_W-1:0] zOut
);
  localparam int E  = NBITS / WORD_W + 1;
  localparam int K  = (NBITS + NPE) / NPE;
  localparam int KW = (K > 1) ? $clog2(K) : 1;
  localparam int EW = (E > 1) ? $clog2(E) : 1;

  mmCtrlT        ctrl;
  logic [KW-1:0] kIdx;
  logic [EW-1:0] wIdx;
  logic          fifoEmpty, finalCap;

  mmCtrl #(.NBITS(NBITS), .WORD_W(WORD_W), .NPE(NPE)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .fifoEmpty(fifoEmpty), .finalCap(finalCap),
    .ctrl(ctrl), .kIdx(kIdx), .wIdx(wIdx), .busy(busy), .done(done)
  );

  mmDatapath #(.NBITS(NBITS), .WORD_W(WORD_W), .NPE(NPE)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .kIdx(kIdx), .wIdx(wIdx),
    .xIn(xIn), .yIn(yIn), .mHatIn(mHatIn),
    .fifoEmpty(fifoEmpty), .finalCap(finalCap), .zOut(zOut)
  );
endmodule

// File: tb/montRadix2Array_tb_top.sv
`timescale 1ns/1ps
module montRadix2Array_tb_top;
  localparam int NB = 16;
  localparam int WW = 4;
  localparam int E  = NB / WW + 1;
  localparam int ZW = E * WW;
  localparam int PA = 2;    // recirculated words arrive early
  localparam int PB = 10;   // first element stalls every pass

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NB:0]   xIn = '0;
  logic [ZW-1:0] yIn = '0, mHatIn = '0;
  logic busyA, doneA, busyB, doneB;
  logic [ZW-1:0] zA, zB;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  montRadix2Array #(.NBITS(NB), .WORD_W(WW), .NPE(PA)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .xIn(xIn), .yIn(yIn), .mHatIn(mHatIn),
    .busy(busyA), .done(doneA), .zOut(zA));
  montRadix2Array #(.NBITS(NB), .WORD_W(WW), .NPE(PB)) dutStall_i (
    .clk(clk), .rstN(rstN), .start(start), .xIn(xIn), .yIn(yIn), .mHatIn(mHatIn),
    .busy(busyB), .done(doneB), .zOut(zB));

  function automatic int expDone(input int p);
    int k, per;
    k   = (NB + p) / p;
    per = (E > p + 2) ? E : p + 2;
    return (k - 1) * per + E + p + 2;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!busyA && !busyB, "R5", "busy after reset", busyA + busyB, 0);
    check(!doneA && !doneB, "R5", "done after reset", doneA + doneB, 0);
    check(zA == '0 && zB == '0, "R5", "zOut after reset", longint'(zA) + longint'(zB), 0);
  endtask

  // one operation on both instances; disturb pulses start and alters operands mid-run (R6)
  task automatic runOp(input string name, input logic [NB:0] xv, input longint yv,
                       input longint mv, input bit disturb, input bit expectZero);
    int dA = -1, dB = -1, nA = 0, nB = 0;
    logic [ZW-1:0] rA = '0, rB = '0;
    longint lhs, refv;
    @(negedge clk);
    xIn = xv; yIn = ZW'(yv); mHatIn = ZW'((mv + 1) / 2); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 1; cyc <= 70; cyc++) begin
      if (cyc == 1) check(busyA && busyB, "R5", {name, " busy in cycle 1"}, busyA + busyB, 2);
      if (doneA) begin
        nA++;
        if (nA == 1) begin
          dA = cyc; rA = zA;
          check(!busyA, "R5", {name, " busy low at done (P=2)"}, busyA, 0);
        end
      end
      if (doneB) begin
        nB++;
        if (nB == 1) begin
          dB = cyc; rB = zB;
          check(!busyB, "R5", {name, " busy low at done (P=10)"}, busyB, 0);
        end
      end
      if (disturb && cyc == 10) begin
        start = 1'b1; xIn = ~xv; yIn = ZW'(mv / 3); mHatIn = ZW'(mv);
      end
      if (disturb && cyc == 11) start = 1'b0;
      if (cyc == 69) begin
        check(zA == rA, "R4", {name, " zOut held (P=2)"}, longint'(zA), longint'(rA));
        check(zB == rB, "R4", {name, " zOut held (P=10)"}, longint'(zB), longint'(rB));
      end
      @(negedge clk);
    end
    check(nA == 1, disturb ? "R6" : "R4", {name, " done pulses (P=2)"}, nA, 1);
    check(nB == 1, disturb ? "R6" : "R4", {name, " done pulses (P=10)"}, nB, 1);
    check(dA == expDone(PA), "R4", {name, " done cycle (P=2)"}, dA, expDone(PA));
    check(dB == expDone(PB), "R7", {name, " done cycle with stalls (P=10)"}, dB, expDone(PB));
    refv = (longint'(xv) * yv) % mv;
    lhs  = (longint'(rA) << NB) % mv;
    check(lhs == refv, "R1", {name, " congruence (P=2)"}, lhs, refv);
    lhs  = (longint'(rB) << NB) % mv;
    check(lhs == refv, "R8", {name, " congruence with surplus slots, R9 recirculation (P=10)"}, lhs, refv);
    check(longint'(rA) < 3 * mv, "R2", {name, " bound (P=2)"}, longint'(rA), 3 * mv);
    check(longint'(rB) < 3 * mv, "R2", {name, " bound (P=10)"}, longint'(rB), 3 * mv);
    if (expectZero) begin
      check(rA == '0, "R3", {name, " exact zero (P=2)"}, longint'(rA), 0);
      check(rB == '0, "R3", {name, " exact zero (P=10)"}, longint'(rB), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    runOp("small",     17'd5,      7,     13,    1'b0, 1'b0);
    runOp("top bit",   17'h10000,  40000, 65521, 1'b0, 1'b0);
    runOp("all ones",  17'h1FFFF,  65520, 65521, 1'b0, 1'b0);
    runOp("mixed",     17'h0A5C3,  12345, 54321, 1'b0, 1'b0);
    runOp("x zero",    17'd0,      999,   1001,  1'b0, 1'b1);
    runOp("y zero",    17'h1ABCD,  0,     1001,  1'b0, 1'b1);
    runOp("restart",   17'h13579,  30001, 60013, 1'b1, 1'b0);
    runOp("after",     17'h0F0F0,  2,     3,     1'b0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule